// File: doc/BRIEF.md
# Guarded Ring-Oscillator Control Register File

This block is the bus-facing register file of a ring-oscillator controller. A simple APB-style write strobe (select, enable and write all high) updates a small set of control words. Each word accepts only particular magic codes or a matching key field. A write that carries any other value is not stored. The affected setting is instead forced to a fail-safe value, and a sticky error flag is raised. Software clears that flag by writing a one to it in the status word.

The registered outputs drive the oscillator analogue: an enable, a 12-bit frequency-range code, eight 3-bit stage drive strengths, a dormant request, a post-divider ratio and the phase-shifted output controls. The register file also holds an 8-bit one-shot down counter that ticks on every clock, and a status word. The status word gathers two indications from the oscillator together with the error flag and the current enable. Reads are combinational from the address. Any offset that is not mapped reads as zero, and bits with no function read as zero. The reset input is asserted asynchronously and its release is synchronised inside the block, so the registers leave reset two clock edges after `rst_n` rises.

Top module: `ring_osc_ctrl_regs`

## Requirements
- R1: After reset the words read as follows: control word (0x00) 0x00FABAA0, both drive words 0, pause word 0x77616B65, divider word 0xAB0, phase word 0x008, count 0 and error flag 0. The outputs are `osc_en_o`=1, `div_ratio_o`=16, `phase_en_o`=1, `phase_flip_o`=0, `phase_shift_o`=0 and `dormant_o`=0.
- R2: Bits 23:12 of a write to offset 0x00 select the oscillator enable. 0xD1E turns `osc_en_o` off and 0xFAB turns it on. Any other code turns it on and raises the error flag. These bits read back as 0xD1E or 0xFAB.
- R3: Bits 11:0 of a write to offset 0x00 are stored only if they hold one of 0xFA4, 0xFA5, 0xFA7 or 0xFA6. Any other code stores 0xFA4 and raises the error flag. The stored code drives `range_code_o` and reads back in bits 11:0.
- R4: Offsets 0x04 and 0x08 hold the drive strengths for stages 0–3 and 4–7. Within each word, the strength of the lowest stage sits in bits 2:0, the next in 6:4, then 10:8, then 14:12. The strengths are stored only when bits 31:16 equal 0x9696. Otherwise all four stages of that word become 0 and the error flag is raised. Stage k drives `drive_o[3k+2:3k]`. The key bits read back as zero.
- R5: At offset 0x0C, 0x636F6D61 sets `dormant_o` and 0x77616B65 clears it. Any other word clears it and raises the error flag. The word reads back as whichever of the two codes is in force.
- R6: At offset 0x10, a value of 0xAA0+d with d from 0 to 31 selects d. Any other value selects 31 and raises the error flag. `div_ratio_o` is d, except that d=0 gives 32. The word reads back as 0xAA0+d.
- R7: At offset 0x14, bits 11:4 must equal 0xAA for the write to store enable (bit 3), invert (bit 2) and shift (bits 1:0). With any other key the block sets enable=1, invert=0 and shift=0, and raises the error flag. The word reads back with bits 11:4 as zero.
- R8: The status word at offset 0x18 reads `osc_stable_i` in bit 31, the error flag in bit 24, `div_running_i` in bit 16 and `osc_en_o` in bit 12. A write with bit 24 set clears the flag. A write with bit 24 clear leaves it set. If a failed check and a clear fall in the same cycle, the flag stays set.
- R9: A write to offset 0x20 loads bits 7:0 into the counter. A non-zero count drops by one on each following clock edge and holds at zero.
- R10: Offsets other than 0x00–0x20 in steps of four read as zero. No state changes unless `psel`, `penable` and `pwrite` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the counter |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write direction |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from `paddr` |
| osc_stable_i | input | 1 | Oscillator running and stable |
| div_running_i | input | 1 | Post-divider running |
| osc_en_o | output | 1 | Oscillator enable |
| range_code_o | output | 12 | Frequency-range code |
| drive_o | output | 24 | Eight 3-bit stage drive strengths |
| dormant_o | output | 1 | Dormant request |
| div_ratio_o | output | 6 | Divide ratio, 1 to 32 |
| phase_en_o | output | 1 | Phase output enable |
| phase_flip_o | output | 1 | Phase output invert |
| phase_shift_o | output | 2 | Phase shift in input clocks |

## Verification
The assertions assume that the bus never presents a write to a checked word in the same cycle as a write to the status word. They also assume that `paddr` and `pwdata` are stable while the strobe is high. The stimulus therefore issues one two-phase transfer at a time and changes the bus signals only on falling edges. The status inputs are held constant during each transfer, so the status read-back can be predicted, and they are changed only between transfers.

// File: rtl/ring_osc_pkg.sv
package ring_osc_pkg;
  localparam int DATA_W     = 32;
  localparam int STR_W      = 3;
  localparam int N_STAGE    = 8;
  localparam int STG_PER_WD = 4;
  localparam int N_DRV_WD   = N_STAGE / STG_PER_WD;
  localparam int DIV_W      = 5;
  localparam int CNT_W      = 8;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_DRV0   = 8'h04;
  localparam logic [7:0] OFF_PAUSE  = 8'h0c;
  localparam logic [7:0] OFF_DIV    = 8'h10;
  localparam logic [7:0] OFF_PHASE  = 8'h14;
  localparam logic [7:0] OFF_STAT   = 8'h18;
  localparam logic [7:0] OFF_COUNT  = 8'h20;

  localparam logic [11:0] EN_CODE_OFF  = 12'hd1e;
  localparam logic [11:0] EN_CODE_ON   = 12'hfab;
  localparam logic [11:0] RNG_LOW      = 12'hfa4;
  localparam logic [11:0] RNG_MED      = 12'hfa5;
  localparam logic [11:0] RNG_HIGH     = 12'hfa7;
  localparam logic [11:0] RNG_OVER     = 12'hfa6;
  localparam logic [11:0] RNG_RST      = 12'haa0;
  localparam logic [15:0] DRV_KEY      = 16'h9696;
  localparam logic [31:0] PAUSE_SLEEP  = 32'h636f6d61;
  localparam logic [31:0] PAUSE_RUN    = 32'h77616b65;
  localparam logic [11:0] DIV_BASE     = 12'haa0;
  localparam logic [DIV_W-1:0] DIV_RST  = 5'd16;
  localparam logic [DIV_W-1:0] DIV_SAFE = 5'd31;
  localparam logic [7:0]  PHASE_KEY    = 8'haa;

  localparam int ST_STABLE  = 31;
  localparam int ST_BAD     = 24;
  localparam int ST_DIVRUN  = 16;
  localparam int ST_ENABLED = 12;

  function automatic logic range_legal(input logic [11:0] c);
    return (c == RNG_LOW) || (c == RNG_MED) || (c == RNG_HIGH) || (c == RNG_OVER);
  endfunction

  function automatic logic div_legal(input logic [11:0] c);
    return c[11:DIV_W] == DIV_BASE[11:DIV_W];
  endfunction
endpackage

// File: rtl/osc_rst_sync.sv
module osc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/osc_ctrl_fields.sv
module osc_ctrl_fields
  import ring_osc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_ctrl,
  input  logic [N_DRV_WD-1:0]      we_drv,
  input  logic                     we_pause,
  input  logic                     we_div,
  input  logic                     we_phase,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     en_q,
  output logic [11:0]              range_q,
  output logic [N_STAGE*STR_W-1:0] drive_q,
  output logic                     dormant_q,
  output logic [DIV_W-1:0]         div_q,
  output logic                     ph_en_q,
  output logic                     ph_flip_q,
  output logic [1:0]               ph_shift_q,
  output logic                     bad_o
);
  localparam int GRP_W = STG_PER_WD * STR_W;

  logic             en_d;
  logic [11:0]      range_d;
  logic             dormant_d;
  logic [DIV_W-1:0] div_d;
  logic             ph_en_d, ph_flip_d;
  logic [1:0]       ph_shift_d;
  logic             ctrl_bad, pause_bad, div_bad, phase_bad;
  logic [N_DRV_WD-1:0] drv_bad;

  // next-state for control, pause, divider and phase words
  always_comb begin
    ctrl_bad = 1'b0;
    case (wdata[23:12])
      EN_CODE_OFF: en_d = 1'b0;
      EN_CODE_ON:  en_d = 1'b1;
      default: begin
        en_d     = 1'b1;
        ctrl_bad = 1'b1;
      end
    endcase
    if (range_legal(wdata[11:0])) begin
      range_d = wdata[11:0];
    end else begin
      range_d  = RNG_LOW;
      ctrl_bad = 1'b1;
    end

    pause_bad = 1'b0;
    if (wdata == PAUSE_SLEEP) begin
      dormant_d = 1'b1;
    end else begin
      dormant_d = 1'b0;
      pause_bad = (wdata != PAUSE_RUN);
    end

    if (div_legal(wdata[11:0])) begin
      div_d   = wdata[DIV_W-1:0];
      div_bad = 1'b0;
    end else begin
      div_d   = DIV_SAFE;
      div_bad = 1'b1;
    end

    if (wdata[11:4] == PHASE_KEY) begin
      ph_en_d    = wdata[3];
      ph_flip_d  = wdata[2];
      ph_shift_d = wdata[1:0];
      phase_bad  = 1'b0;
    end else begin
      ph_en_d    = 1'b1;
      ph_flip_d  = 1'b0;
      ph_shift_d = 2'd0;
      phase_bad  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b1;
      range_q    <= RNG_RST;
      dormant_q  <= 1'b0;
      div_q      <= DIV_RST;
      ph_en_q    <= 1'b1;
      ph_flip_q  <= 1'b0;
      ph_shift_q <= 2'd0;
    end else begin
      if (we_ctrl) begin
        en_q    <= en_d;
        range_q <= range_d;
      end
      if (we_pause) dormant_q <= dormant_d;
      if (we_div)   div_q     <= div_d;
      if (we_phase) begin
        ph_en_q    <= ph_en_d;
        ph_flip_q  <= ph_flip_d;
        ph_shift_q <= ph_shift_d;
      end
    end
  end

  // one drive word per group of four stages
  for (genvar g = 0; g < N_DRV_WD; g++) begin : g_drv
    logic [GRP_W-1:0] grp_d;
    logic [GRP_W-1:0] grp_q;
    logic             key_ok;

    assign key_ok = (wdata[31:16] == DRV_KEY);

    always_comb begin
      grp_d = '0;
      if (key_ok) begin
        for (int s = 0; s < STG_PER_WD; s++) begin
          grp_d[s*STR_W +: STR_W] = wdata[s*4 +: STR_W];
        end
      end
    end

    assign drv_bad[g] = we_drv[g] & ~key_ok;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         grp_q <= '0;
      else if (we_drv[g]) grp_q <= grp_d;
    end

    assign drive_q[g*GRP_W +: GRP_W] = grp_q;

    AST_DRV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (we_drv[g] && (wdata[31:16] != DRV_KEY)) |=> (drive_q[g*GRP_W +: GRP_W] == '0)); // R4
  end

  assign bad_o = (we_ctrl & ctrl_bad) | (we_pause & pause_bad) | (we_div & div_bad) |
                 (we_phase & phase_bad) | (|drv_bad);

  AST_DIV_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (we_div && !div_legal(wdata[11:0])) |=> (div_q == DIV_SAFE)); // R6
  AST_PAUSE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_pause && (wdata != PAUSE_SLEEP)) |=> !dormant_q); // R5
  AST_EN_FAILSAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_ctrl && (wdata[23:12] != EN_CODE_OFF)) |=> en_q); // R2
  AST_RANGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    we_ctrl |=> range_legal(range_q)); // R3
endmodule

// File: rtl/osc_sticky_flag.sv
module osc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;

  always_comb flag_d = set_i | (flag_o & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag_o <= 1'b0;
    else if (set_i || clr_i)    flag_o <= flag_d;
  end

  AST_BAD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R8
  AST_BAD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o); // R8
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && flag_o) |=> flag_o); // R8
endmodule

// File: rtl/osc_oneshot_count.sv
module osc_oneshot_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = load_i | (cnt_o != '0);
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_o - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (cnt_ce) cnt_o <= cnt_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - W'(1))); // R9
  AST_CNT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_o == '0) |=> (cnt_o == '0)); // R9
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_o == $past(load_val_i))); // R9
endmodule

// File: rtl/ring_osc_ctrl_regs.sv
module ring_osc_ctrl_regs
  import ring_osc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:0]        paddr,
  input  logic [DATA_W-1:0]        pwdata,
  output logic [DATA_W-1:0]        prdata,
  input  logic                     osc_stable_i,
  input  logic                     div_running_i,
  output logic                     osc_en_o,
  output logic [11:0]              range_code_o,
  output logic [N_STAGE*STR_W-1:0] drive_o,
  output logic                     dormant_o,
  output logic [DIV_W:0]           div_ratio_o,
  output logic                     phase_en_o,
  output logic                     phase_flip_o,
  output logic [1:0]               phase_shift_o
);
  localparam int GRP_W = STG_PER_WD * STR_W;

  logic                rst_s_n;
  logic                wr_s;
  logic                we_ctrl, we_pause, we_div, we_phase, we_stat, we_cnt;
  logic [N_DRV_WD-1:0] we_drv;
  logic                bad_set, bad_flag;
  logic [DIV_W-1:0]    div_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [DATA_W-1:0]   drv_rd [N_DRV_WD];
  logic [N_DRV_WD-1:0] drv_hit;

  osc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign wr_s     = psel & penable & pwrite;
  assign we_ctrl  = wr_s & (paddr == OFF_CTRL[ADDR_W-1:0]);
  assign we_pause = wr_s & (paddr == OFF_PAUSE[ADDR_W-1:0]);
  assign we_div   = wr_s & (paddr == OFF_DIV[ADDR_W-1:0]);
  assign we_phase = wr_s & (paddr == OFF_PHASE[ADDR_W-1:0]);
  assign we_stat  = wr_s & (paddr == OFF_STAT[ADDR_W-1:0]);
  assign we_cnt   = wr_s & (paddr == OFF_COUNT[ADDR_W-1:0]);

  for (genvar g = 0; g < N_DRV_WD; g++) begin : g_dec
    localparam logic [7:0] GOFF = OFF_DRV0 + 8'(4 * g);
    assign drv_hit[g] = (paddr == GOFF[ADDR_W-1:0]);
    assign we_drv[g]  = wr_s & drv_hit[g];
    always_comb begin
      drv_rd[g] = '0;
      for (int s = 0; s < STG_PER_WD; s++) begin
        drv_rd[g][s*4 +: STR_W] = drive_o[g*GRP_W + s*STR_W +: STR_W];
      end
    end
  end

  osc_ctrl_fields u_fields (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .we_ctrl    (we_ctrl),
    .we_drv     (we_drv),
    .we_pause   (we_pause),
    .we_div     (we_div),
    .we_phase   (we_phase),
    .wdata      (pwdata),
    .en_q       (osc_en_o),
    .range_q    (range_code_o),
    .drive_q    (drive_o),
    .dormant_q  (dormant_o),
    .div_q      (div_q),
    .ph_en_q    (phase_en_o),
    .ph_flip_q  (phase_flip_o),
    .ph_shift_q (phase_shift_o),
    .bad_o      (bad_set)
  );

  osc_sticky_flag u_bad (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .set_i  (bad_set),
    .clr_i  (we_stat & pwdata[ST_BAD]),
    .flag_o (bad_flag)
  );

  osc_oneshot_count #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .load_i     (we_cnt),
    .load_val_i (pwdata[CNT_W-1:0]),
    .cnt_o      (cnt_q)
  );

  assign div_ratio_o = (div_q == '0) ? (DIV_W+1)'(1 << DIV_W) : {1'b0, div_q};

  // read multiplexer
  always_comb begin
    prdata = '0;
    if (paddr == OFF_CTRL[ADDR_W-1:0]) begin
      prdata[23:12] = osc_en_o ? EN_CODE_ON : EN_CODE_OFF;
      prdata[11:0]  = range_code_o;
    end else if (paddr == OFF_PAUSE[ADDR_W-1:0]) begin
      prdata = dormant_o ? PAUSE_SLEEP : PAUSE_RUN;
    end else if (paddr == OFF_DIV[ADDR_W-1:0]) begin
      prdata[11:0] = DIV_BASE | {7'd0, div_q};
    end else if (paddr == OFF_PHASE[ADDR_W-1:0]) begin
      prdata[3:0] = {phase_en_o, phase_flip_o, phase_shift_o};
    end else if (paddr == OFF_STAT[ADDR_W-1:0]) begin
      prdata[ST_STABLE]  = osc_stable_i;
      prdata[ST_BAD]     = bad_flag;
      prdata[ST_DIVRUN]  = div_running_i;
      prdata[ST_ENABLED] = osc_en_o;
    end else if (paddr == OFF_COUNT[ADDR_W-1:0]) begin
      prdata[CNT_W-1:0] = cnt_q;
    end else begin
      for (int g = 0; g < N_DRV_WD; g++) begin
        if (drv_hit[g]) prdata = drv_rd[g];
      end
    end
  end

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_s |=> ($stable(osc_en_o) && $stable(range_code_o) && $stable(drive_o) &&
               $stable(dormant_o) && $stable(div_ratio_o) && $stable(phase_en_o))); // R10
  AST_RATIO_SPAN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (div_ratio_o != '0) && (div_ratio_o <= (DIV_W+1)'(1 << DIV_W))); // R6
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({we_ctrl, we_drv, we_pause, we_div, we_phase, we_stat, we_cnt})); // R10
endmodule

// File: tb/ring_osc_ctrl_regs_tb_top.sv
module ring_osc_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, psel, penable, pwrite;
  logic [5:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        osc_stable_i, div_running_i;
  logic        osc_en_o, dormant_o, phase_en_o, phase_flip_o;
  logic [11:0] range_code_o;
  logic [23:0] drive_o;
  logic [5:0]  div_ratio_o;
  logic [1:0]  phase_shift_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ring_osc_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .osc_stable_i(osc_stable_i), .div_running_i(div_running_i),
    .osc_en_o(osc_en_o), .range_code_o(range_code_o), .drive_o(drive_o),
    .dormant_o(dormant_o), .div_ratio_o(div_ratio_o), .phase_en_o(phase_en_o),
    .phase_flip_o(phase_flip_o), .phase_shift_o(phase_shift_o)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] wd;
    logic [31:0] ex;
    logic        bad;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 32'h00d1efa5, 32'h00d1efa5, 1'b0, 4'd2},  // R2 off, medium
    '{8'h00, 32'h00fabfa7, 32'h00fabfa7, 1'b0, 4'd2},  // R2 on, high
    '{8'h00, 32'h00123fa6, 32'h00fabfa6, 1'b1, 4'd2},  // R2 bad enable code
    '{8'h00, 32'h00fab555, 32'h00fabfa4, 1'b1, 4'd3},  // R3 bad range code
    '{8'h04, 32'h96967531, 32'h00007531, 1'b0, 4'd4},  // R4 stages 0..3
    '{8'h08, 32'h96960246, 32'h00000246, 1'b0, 4'd4},  // R4 stages 4..7
    '{8'h04, 32'h96977777, 32'h00000000, 1'b1, 4'd4},  // R4 wrong key
    '{8'h0c, 32'h636f6d61, 32'h636f6d61, 1'b0, 4'd5},  // R5 dormant
    '{8'h0c, 32'hdeadbeef, 32'h77616b65, 1'b1, 4'd5},  // R5 invalid -> wake
    '{8'h10, 32'h00000aa0, 32'h00000aa0, 1'b0, 4'd6},  // R6 d=0
    '{8'h10, 32'h00000abf, 32'h00000abf, 1'b0, 4'd6},  // R6 d=31
    '{8'h10, 32'h00000ac0, 32'h00000abf, 1'b1, 4'd6},  // R6 out of range
    '{8'h14, 32'h00000aa6, 32'h00000006, 1'b0, 4'd7},  // R7 good key
    '{8'h14, 32'h00000ab7, 32'h00000008, 1'b1, 4'd7},  // R7 wrong key
    '{8'h24, 32'hffffffff, 32'h00000000, 1'b0, 4'd10}  // R10 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input bit with_en);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a[5:0]; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = with_en;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    paddr = a[5:0];
    #1;
    d = prdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; osc_stable_i = 1'b0; div_running_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(8'h00, rd); check("R1 ctrl", rd, 32'h00fabaa0);
    bus_rd(8'h04, rd); check("R1 drv0", rd, 32'h0);
    bus_rd(8'h08, rd); check("R1 drv1", rd, 32'h0);
    bus_rd(8'h0c, rd); check("R1 pause", rd, 32'h77616b65);
    bus_rd(8'h10, rd); check("R1 div", rd, 32'h00000ab0);
    bus_rd(8'h14, rd); check("R1 phase", rd, 32'h00000008);
    bus_rd(8'h18, rd); check("R1 status", rd, 32'h00001000);
    bus_rd(8'h20, rd); check("R1 count", rd, 32'h0);
    check("R1 outs", {26'd0, osc_en_o, dormant_o, phase_en_o, phase_flip_o, phase_shift_o},
          {26'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0});
    check("R1 ratio", {26'd0, div_ratio_o}, 32'd16);

    // table walk: write, read back, check error flag, clear it
    for (int i = 0; i < NV; i++) begin
      bus_wr(VECS[i].a, VECS[i].wd, 1'b1);
      bus_rd(VECS[i].a, rd);
      check($sformatf("R%0d row %0d", VECS[i].rq, i), rd, VECS[i].ex);
      bus_rd(8'h18, rd);
      check($sformatf("R8 flag row %0d", i), {31'd0, rd[24]}, {31'd0, VECS[i].bad});
      bus_wr(8'h18, 32'h01000000, 1'b1);
    end

    // R6 ratio outputs
    bus_wr(8'h10, 32'h00000aa0, 1'b1);
    check("R6 ratio d=0", {26'd0, div_ratio_o}, 32'd32);
    bus_wr(8'h10, 32'h00000aa5, 1'b1);
    check("R6 ratio d=5", {26'd0, div_ratio_o}, 32'd5);

    // R4 stage mapping at the port
    bus_wr(8'h04, 32'h96961234, 1'b1);
    bus_wr(8'h08, 32'h96965670, 1'b1);
    check("R4 drive port", {8'd0, drive_o}, {8'd0, 3'd5, 3'd6, 3'd7, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4});

    // R2 R3 R5 R7 ports
    bus_wr(8'h00, 32'h00d1efa7, 1'b1);
    check("R2 en port", {31'd0, osc_en_o}, 32'd0);
    check("R3 range port", {20'd0, range_code_o}, 32'h00000fa7);
    bus_rd(8'h18, rd); check("R8 enabled bit", rd, 32'h0);
    bus_wr(8'h0c, 32'h636f6d61, 1'b1);
    check("R5 dormant port", {31'd0, dormant_o}, 32'd1);
    bus_wr(8'h14, 32'h00000aa7, 1'b1);
    check("R7 phase port", {28'd0, phase_en_o, phase_flip_o, phase_shift_o}, 32'h7);

    // R8 layout and clear semantics
    osc_stable_i = 1'b1; div_running_i = 1'b1;
    bus_wr(8'h00, 32'h00fabfa4, 1'b1);
    bus_wr(8'h10, 32'h00000000, 1'b1);
    bus_rd(8'h18, rd); check("R8 layout", rd, 32'h81011000);
    bus_wr(8'h18, 32'hfeffffff, 1'b1);
    bus_rd(8'h18, rd); check("R8 zero keeps flag", rd, 32'h81011000);
    bus_wr(8'h18, 32'h01000000, 1'b1);
    bus_rd(8'h18, rd); check("R8 clear", rd, 32'h80011000);

    // R9 counter
    bus_wr(8'h20, 32'h00000003, 1'b1);
    bus_rd(8'h20, rd); check("R9 load", rd, 32'd3);
    @(posedge clk); @(negedge clk);
    bus_rd(8'h20, rd); check("R9 step", rd, 32'd2);
    repeat (2) @(negedge clk);
    bus_rd(8'h20, rd); check("R9 zero", rd, 32'd0);
    repeat (3) @(negedge clk);
    bus_rd(8'h20, rd); check("R9 parked", rd, 32'd0);
    bus_wr(8'h20, 32'h000000ff, 1'b1);
    bus_wr(8'h20, 32'h00000000, 1'b1);
    bus_rd(8'h20, rd); check("R9 stop", rd, 32'd0);

    // R10 strobe without penable, unmapped read
    bus_wr(8'h10, 32'h00000aa7, 1'b0);
    check("R10 no penable", {26'd0, div_ratio_o}, 32'd31);
    bus_rd(8'h1c, rd); check("R10 unmapped", rd, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule